// File: doc/BRIEF.md
# Memory Access Alignment and Steering Unit

This unit sits between a processor's register file and a little-endian data bus that is one machine word wide. For every memory opcode it adds a base register value to a sign-extended literal offset. It checks the result against the natural alignment of the access size and presents a word-aligned bus address together with per-byte strobes. On stores it shifts the register data onto the right byte lanes. On loads it picks the addressed byte or halfword out of the returned word and widens it, with either zero fill or sign fill.

The same datapath also forms the register write value for the two literal-load opcodes. One writes the literal into the low half and clears the high half. The other writes the literal into the high half and keeps the low half of the current register value. A misaligned access raises a fault, drives no strobes and leaves the register value as it was.

The request is sampled on a clock edge when `req_valid` is high, and every output belongs to that request one cycle later. The caller presents `rd_data` with the request; it is the word at the aligned address. The memory itself is not part of this block.

Top module: `mem_align_unit`

## Requirements
- R1: For memory opcodes 0x03 to 0x0A, the effective address is `base_val` plus the 16-bit `offset` sign-extended, modulo 2^32. `bus_addr` is that address with bits 1..0 forced to zero. For every other opcode, `bus_addr` is zero.
- R2: Byte load: opcode 0x03 zero-extends and 0x04 sign-extends. The lane is effective address bits 1..0, and lane 0 is `rd_data[7:0]`, so lane n is bits 8n+7..8n.
- R3: Halfword load: opcode 0x05 zero-extends and 0x06 sign-extends. Effective address bit 1 selects `rd_data[15:0]` (0) or `rd_data[31:16]` (1).
- R4: Word load (opcode 0x07) returns `rd_data` unchanged in `reg_result`.
- R5: A byte access never faults. A halfword access faults when address bit 0 is 1. A word access faults when address bits 1..0 are not zero.
- R6: On a fault, `misalign` is 1, `bus_strb` is 0, `bus_wdata` is 0, `bus_we` is 0, `reg_wr` is 0 and `reg_result` equals `old_val`.
- R7: Stores set `bus_we` to 1. STB (0x08) sets strobe bit n for lane n and places `store_val[7:0]` in that lane. STH (0x09) sets two adjacent strobes and places `store_val[15:0]` in that half. STW (0x0A) sets all four strobes and passes `store_val`. Bytes outside the strobes are zero.
- R8: An aligned load drives strobes for exactly the bytes it reads, with `bus_we` at 0 and `reg_wr` at 1.
- R9: LLI (opcode 0x0B) gives `reg_result` = {16'h0, offset} with `reg_wr` at 1, no strobes and no fault.
- R10: LUI (opcode 0x0C) gives `reg_result` = {offset, old_val[15:0]} with `reg_wr` at 1, no strobes and no fault.
- R11: Any other opcode gives no strobes, no fault, `bus_we` 0, `reg_wr` 0, `bus_addr` 0 and `reg_result` equal to `old_val`.
- R12: Outputs follow a sampled request one cycle later, with `rsp_valid` at 1. A cycle without a request gives `rsp_valid`, `bus_strb`, `bus_we`, `reg_wr` and `misalign` all 0, and so does reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| opcode | input | 6 | Instruction opcode |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Signed offset, or literal for LLI/LUI |
| store_val | input | 32 | Register data to store |
| old_val | input | 32 | Current value of the destination register |
| rd_data | input | 32 | Memory word at the aligned address |
| rsp_valid | output | 1 | Outputs belong to the previous request |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_strb | output | 4 | Byte strobes, bit n for lane n |
| bus_we | output | 1 | Write access |
| bus_wdata | output | 32 | Lane-steered store data |
| reg_result | output | 32 | Register write value |
| reg_wr | output | 1 | Register write enable |
| misalign | output | 1 | Alignment fault |

## Verification
The bench builds the unit with its default widths, a 32-bit word and a 16-bit offset. These give four byte lanes and two halfword positions, and directed accesses reach each of them with both zero fill and sign fill. With 16-bit offsets the bench can use negative offsets that borrow across the low address bits, and base values whose sum wraps past 2^32. Directed and pseudo-random requests, mixed with idle cycles, exercise every alignment class against a behavioural model.

// File: rtl/mau_pkg.sv
package mau_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OP_LDB  = 6'h03;
  localparam logic [OPC_W-1:0] OP_LDBS = 6'h04;
  localparam logic [OPC_W-1:0] OP_LDH  = 6'h05;
  localparam logic [OPC_W-1:0] OP_LDHS = 6'h06;
  localparam logic [OPC_W-1:0] OP_LDW  = 6'h07;
  localparam logic [OPC_W-1:0] OP_STB  = 6'h08;
  localparam logic [OPC_W-1:0] OP_STH  = 6'h09;
  localparam logic [OPC_W-1:0] OP_STW  = 6'h0A;
  localparam logic [OPC_W-1:0] OP_LLI  = 6'h0B;
  localparam logic [OPC_W-1:0] OP_LUI  = 6'h0C;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_HALF = 2'd2,
    SZ_WORD = 2'd3
  } acc_size_e;

  typedef struct packed {
    acc_size_e size;
    logic      is_load;
    logic      is_store;
    logic      sign_ext;
    logic      is_lli;
    logic      is_lui;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [OPC_W-1:0] op);
    op_dec_t d;
    d = '{size: SZ_NONE, is_load: 1'b0, is_store: 1'b0,
          sign_ext: 1'b0, is_lli: 1'b0, is_lui: 1'b0};
    case (op)
      OP_LDB:  begin d.size = SZ_BYTE; d.is_load = 1'b1; end
      OP_LDBS: begin d.size = SZ_BYTE; d.is_load = 1'b1; d.sign_ext = 1'b1; end
      OP_LDH:  begin d.size = SZ_HALF; d.is_load = 1'b1; end
      OP_LDHS: begin d.size = SZ_HALF; d.is_load = 1'b1; d.sign_ext = 1'b1; end
      OP_LDW:  begin d.size = SZ_WORD; d.is_load = 1'b1; end
      OP_STB:  begin d.size = SZ_BYTE; d.is_store = 1'b1; end
      OP_STH:  begin d.size = SZ_HALF; d.is_store = 1'b1; end
      OP_STW:  begin d.size = SZ_WORD; d.is_store = 1'b1; end
      OP_LLI:  d.is_lli = 1'b1;
      OP_LUI:  d.is_lui = 1'b1;
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mau_agu.sv
module mau_agu
  import mau_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]    base_val,
  input  logic [IMM_W-1:0]     offset,
  input  acc_size_e            size,
  output logic [DATA_W-1:0]    word_addr,
  output logic [LANE_BITS-1:0] lane,
  output logic                 misaligned
);

  logic [DATA_W-1:0] eff_addr;
  logic [DATA_W-1:0] off_ext;

  always_comb begin
    off_ext   = {{(DATA_W-IMM_W){offset[IMM_W-1]}}, offset};
    eff_addr  = base_val + off_ext;
    lane      = eff_addr[LANE_BITS-1:0];
    word_addr = {eff_addr[DATA_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
  end

  always_comb begin
    unique case (size)
      SZ_HALF: misaligned = lane[0];
      SZ_WORD: misaligned = |lane;
      default: misaligned = 1'b0;
    endcase
  end

endmodule

// File: rtl/mau_store_steer.sv
module mau_store_steer
  import mau_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  acc_size_e            size,
  input  logic [LANE_BITS-1:0] lane,
  input  logic [DATA_W-1:0]    store_val,
  output logic [LANES-1:0]     strb,
  output logic [DATA_W-1:0]    wdata
);

  logic [LANE_BITS+2:0] byte_shift;
  logic [LANE_BITS+2:0] half_shift;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LANE_BITS-1:0] IDX = LANE_BITS'(i);
    always_comb begin
      unique case (size)
        SZ_BYTE: strb[i] = (lane == IDX);
        SZ_HALF: strb[i] = (lane[LANE_BITS-1:1] == IDX[LANE_BITS-1:1]);
        SZ_WORD: strb[i] = 1'b1;
        default: strb[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    byte_shift = {lane, 3'b000};
    half_shift = {lane[LANE_BITS-1:1], 4'b0000};
    unique case (size)
      SZ_BYTE: wdata = DATA_W'(store_val[7:0]) << byte_shift;
      SZ_HALF: wdata = DATA_W'(store_val[15:0]) << half_shift;
      SZ_WORD: wdata = store_val;
      default: wdata = '0;
    endcase
  end

endmodule

// File: rtl/mau_load_extract.sv
module mau_load_extract
  import mau_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES     = DATA_W / 8,
  localparam int HALVES    = LANES / 2,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  acc_size_e            size,
  input  logic                 sign_ext,
  input  logic [LANE_BITS-1:0] lane,
  input  logic [DATA_W-1:0]    rd_data,
  output logic [DATA_W-1:0]    load_val
);

  logic [7:0]  bytes_a [LANES];
  logic [15:0] halves_a [HALVES];
  logic [7:0]  sel_byte;
  logic [15:0] sel_half;

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    assign bytes_a[i] = rd_data[8*i +: 8];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign halves_a[h] = rd_data[16*h +: 16];
  end

  always_comb begin
    sel_byte = bytes_a[lane];
    sel_half = halves_a[lane[LANE_BITS-1:1]];
    unique case (size)
      SZ_BYTE: load_val = {{(DATA_W-8){sign_ext & sel_byte[7]}}, sel_byte};
      SZ_HALF: load_val = {{(DATA_W-16){sign_ext & sel_half[15]}}, sel_half};
      SZ_WORD: load_val = rd_data;
      default: load_val = '0;
    endcase
  end

endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit
  import mau_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] base_val,
  input  logic [IMM_W-1:0]  offset,
  input  logic [DATA_W-1:0] store_val,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] bus_addr,
  output logic [LANES-1:0]  bus_strb,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] reg_result,
  output logic              reg_wr,
  output logic              misalign
);

  op_dec_t              dec;
  logic                 is_mem;
  logic [DATA_W-1:0]    word_addr;
  logic [LANE_BITS-1:0] lane;
  logic                 mis_raw;
  logic [LANES-1:0]     st_strb;
  logic [DATA_W-1:0]    st_wdata;
  logic [DATA_W-1:0]    ld_val;

  logic              nxt_valid;
  logic [DATA_W-1:0] nxt_addr;
  logic [LANES-1:0]  nxt_strb;
  logic              nxt_we;
  logic [DATA_W-1:0] nxt_wdata;
  logic [DATA_W-1:0] nxt_result;
  logic              nxt_wr;
  logic              nxt_fault;
  logic              go;

  assign dec    = decode_op(opcode);
  assign is_mem = dec.is_load | dec.is_store;

  mau_agu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_agu (
    .base_val   (base_val),
    .offset     (offset),
    .size       (dec.size),
    .word_addr  (word_addr),
    .lane       (lane),
    .misaligned (mis_raw)
  );

  mau_store_steer #(.DATA_W(DATA_W)) u_steer (
    .size      (dec.size),
    .lane      (lane),
    .store_val (store_val),
    .strb      (st_strb),
    .wdata     (st_wdata)
  );

  mau_load_extract #(.DATA_W(DATA_W)) u_extract (
    .size     (dec.size),
    .sign_ext (dec.sign_ext),
    .lane     (lane),
    .rd_data  (rd_data),
    .load_val (ld_val)
  );

  // next-state logic
  always_comb begin
    go         = req_valid & is_mem & ~mis_raw;
    nxt_valid  = req_valid;
    nxt_fault  = req_valid & is_mem & mis_raw;
    nxt_strb   = go ? st_strb : '0;
    nxt_we     = go & dec.is_store;
    nxt_wr     = req_valid & ((dec.is_load & ~mis_raw) | dec.is_lli | dec.is_lui);
    nxt_addr   = is_mem ? word_addr : '0;
    nxt_wdata  = (go & dec.is_store) ? st_wdata : '0;
    if (dec.is_lli) begin
      nxt_result = {{(DATA_W-IMM_W){1'b0}}, offset};
    end else if (dec.is_lui) begin
      nxt_result = {offset, old_val[DATA_W-IMM_W-1:0]};
    end else if (dec.is_load && !mis_raw) begin
      nxt_result = ld_val;
    end else begin
      nxt_result = old_val;
    end
  end

  // control registers: updated every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      misalign  <= 1'b0;
      bus_strb  <= '0;
      bus_we    <= 1'b0;
      reg_wr    <= 1'b0;
    end else begin
      rsp_valid <= nxt_valid;
      misalign  <= nxt_fault;
      bus_strb  <= nxt_strb;
      bus_we    <= nxt_we;
      reg_wr    <= nxt_wr;
    end
  end

  // data registers: loaded only with a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr   <= '0;
      bus_wdata  <= '0;
      reg_result <= '0;
    end else if (req_valid) begin
      bus_addr   <= nxt_addr;
      bus_wdata  <= nxt_wdata;
      reg_result <= nxt_result;
    end
  end

  // R6
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (bus_strb == '0) && !bus_we && !reg_wr);

  // R1
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[LANE_BITS-1:0] == '0);

  // R7
  store_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (bus_strb != '0) && rsp_valid);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (bus_strb == '0) && !bus_we && !reg_wr && !misalign);

  // R9
  lli_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(opcode) == OP_LLI)
      |-> reg_wr && (reg_result[DATA_W-1:IMM_W] == '0) && (bus_strb == '0));

  // R10
  lui_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(opcode) == OP_LUI)
      |-> reg_wr && (reg_result[DATA_W-IMM_W-1:0] == $past(old_val[DATA_W-IMM_W-1:0])));

  // R5
  byte_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ($past(opcode) == OP_LDB || $past(opcode) == OP_LDBS ||
                   $past(opcode) == OP_STB)) |-> !misalign);

  // R11
  other_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(opcode) > OP_LUI)
      |-> !reg_wr && !misalign && (bus_strb == '0) && (bus_addr == '0));

endmodule

// File: tb/mem_align_unit_test.sv
module mem_align_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  opcode;
  logic [31:0] base_val;
  logic [15:0] offset;
  logic [31:0] store_val;
  logic [31:0] old_val;
  logic [31:0] rd_data;
  logic        rsp_valid;
  logic [31:0] bus_addr;
  logic [3:0]  bus_strb;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] reg_result;
  logic        reg_wr;
  logic        misalign;

  int n_checks;
  int n_fail;
  bit done;

  mem_align_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
    .base_val(base_val), .offset(offset), .store_val(store_val),
    .old_val(old_val), .rd_data(rd_data), .rsp_valid(rsp_valid),
    .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .reg_result(reg_result), .reg_wr(reg_wr),
    .misalign(misalign)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: returns expected outputs for one request.
  task automatic model(input logic v, input logic [5:0] op,
                       input logic [31:0] b, input logic [15:0] o,
                       input logic [31:0] sv, input logic [31:0] ov,
                       input logic [31:0] rd,
                       output logic [31:0] e_addr, output logic [3:0] e_strb,
                       output logic e_we, output logic [31:0] e_wd,
                       output logic [31:0] e_res, output logic e_wr,
                       output logic e_fault, output string tag);
    int size;
    bit ld, st, sx;
    longint unsigned ea_l;
    logic [31:0] ea;
    int ln;
    logic [31:0] mask;
    logic [31:0] piece;
    size = 0; ld = 0; st = 0; sx = 0;
    case (op)
      6'h03: begin size = 1; ld = 1; end
      6'h04: begin size = 1; ld = 1; sx = 1; end
      6'h05: begin size = 2; ld = 1; end
      6'h06: begin size = 2; ld = 1; sx = 1; end
      6'h07: begin size = 4; ld = 1; end
      6'h08: begin size = 1; st = 1; end
      6'h09: begin size = 2; st = 1; end
      6'h0A: begin size = 4; st = 1; end
      default: ;
    endcase
    ea_l = longint'(b) + longint'($signed(o));
    ea = ea_l[31:0];
    ln = int'(ea % 4);
    e_addr = 32'h0; e_strb = 4'h0; e_we = 0; e_wd = 32'h0;
    e_res = ov; e_wr = 0; e_fault = 0; tag = "R11";
    if (size != 0) e_addr = ea & 32'hFFFF_FFFC;
    if (op == 6'h0B) begin
      e_res = {16'h0, o}; e_wr = 1; tag = "R9";
    end else if (op == 6'h0C) begin
      e_res = {o, ov[15:0]}; e_wr = 1; tag = "R10";
    end else if (size != 0 && (ea % size) != 0) begin
      e_fault = 1; tag = "R6";
    end else if (size != 0) begin
      mask = (size == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*size)) - 1);
      e_strb = 4'(((1 << size) - 1) << ln);
      if (ld) begin
        piece = (rd >> (8*ln)) & mask;
        if (sx && piece[8*size-1]) piece = piece | ~mask;
        e_res = piece; e_wr = 1;
        tag = (size == 1) ? "R2" : (size == 2) ? "R3" : "R4";
      end else begin
        e_we = 1; e_wd = (sv & mask) << (8*ln); tag = "R7";
      end
    end
    if (!v) begin
      e_strb = 4'h0; e_we = 0; e_wr = 0; e_fault = 0; tag = "R12";
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(input logic v, input logic [5:0] op, input logic [31:0] b,
                      input logic [15:0] o, input logic [31:0] sv,
                      input logic [31:0] ov, input logic [31:0] rd);
    logic [31:0] e_addr, e_wd, e_res;
    logic [3:0]  e_strb;
    logic        e_we, e_wr, e_fault;
    string       tag;
    req_valid = v; opcode = op; base_val = b; offset = o;
    store_val = sv; old_val = ov; rd_data = rd;
    model(v, op, b, o, sv, ov, rd, e_addr, e_strb, e_we, e_wd, e_res, e_wr, e_fault, tag);
    @(posedge clk);
    @(negedge clk);
    check("R12", "rsp_valid", 32'(rsp_valid), 32'(v));
    check(tag, "strb", 32'(bus_strb), 32'(e_strb));
    check(tag, "we", 32'(bus_we), 32'(e_we));
    check(tag, "reg_wr", 32'(reg_wr), 32'(e_wr));
    check(tag, "misalign", 32'(misalign), 32'(e_fault));
    if (v) begin
      check((tag == "R11") ? "R11" : "R1", "addr", bus_addr, e_addr);
      check(tag, "wdata", bus_wdata, e_wd);
      check(tag, "result", reg_result, e_res);
      if (e_wr && tag != "R9" && tag != "R10")
        check("R8", "load strb", 32'(bus_strb), 32'(e_strb));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    n_checks = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; req_valid = 0; opcode = 0; base_val = 0; offset = 0;
    store_val = 0; old_val = 0; rd_data = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "reset rsp_valid", 32'(rsp_valid), 0);
    check("R12", "reset strb", 32'(bus_strb), 0);
    check("R12", "reset we", 32'(bus_we), 0);
    check("R12", "reset reg_wr", 32'(reg_wr), 0);
    check("R12", "reset misalign", 32'(misalign), 0);
    check("R12", "reset addr", bus_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 byte loads on each lane, both fills
    for (int i = 0; i < 4; i++) begin
      step(1, 6'h03, 32'h0000_2000, 16'(i), 0, 32'hDEAD_BEEF, 32'h80F1_7F05);
      step(1, 6'h04, 32'h0000_2000, 16'(i), 0, 32'hDEAD_BEEF, 32'h80F1_7F05);
    end
    // R3 halfword loads, aligned and misaligned (R5, R6)
    step(1, 6'h05, 32'h100, 16'h0002, 0, 32'h1111_2222, 32'h9ABC_1234);
    step(1, 6'h06, 32'h100, 16'h0002, 0, 32'h1111_2222, 32'h9ABC_1234);
    step(1, 6'h06, 32'h100, 16'h0000, 0, 32'h1111_2222, 32'h9ABC_F234);
    step(1, 6'h05, 32'h100, 16'h0001, 0, 32'h1111_2222, 32'h9ABC_1234);
    step(1, 6'h06, 32'h100, 16'h0003, 0, 32'h1111_2222, 32'h9ABC_1234);
    // R4 word loads, negative offset (R1), misaligned word (R5)
    step(1, 6'h07, 32'h0000_1000, 16'hFFFC, 0, 32'h5, 32'hCAFE_F00D);
    step(1, 6'h07, 32'h0000_1000, 16'h0006, 0, 32'h5, 32'hCAFE_F00D);
    step(1, 6'h07, 32'hFFFF_FFFE, 16'h0006, 0, 32'h5, 32'h0BAD_CAFE);
    // R7 stores on every lane
    for (int i = 0; i < 4; i++)
      step(1, 6'h08, 32'h4000, 16'(i), 32'hA5A5_A5C3, 32'h7, 0);
    step(1, 6'h09, 32'h4000, 16'h0002, 32'h1234_BEEF, 32'h7, 0);
    step(1, 6'h09, 32'h4000, 16'h0001, 32'h1234_BEEF, 32'h7, 0);
    step(1, 6'h0A, 32'h4000, 16'h0008, 32'h1234_BEEF, 32'h7, 0);
    step(1, 6'h0A, 32'h4000, 16'h0002, 32'h1234_BEEF, 32'h7, 0);
    // R9 / R10 literal pair
    step(1, 6'h0B, 32'h4000, 16'hABCD, 0, 32'hFFFF_FFFF, 0);
    step(1, 6'h0C, 32'h4000, 16'h1357, 0, 32'h0000_ABCD, 0);
    // R11 other opcodes, R12 idle cycle
    step(1, 6'h00, 32'h4003, 16'h0001, 32'h1, 32'h2468_ACE0, 32'h3);
    step(1, 6'h19, 32'h4003, 16'h0001, 32'h1, 32'h1357_9BDF, 32'h3);
    step(0, 6'h0A, 32'h4000, 16'h0000, 32'h1, 32'h0, 32'h3);
    step(1, 6'h3F, 32'h0, 16'h0, 32'h1, 32'h0000_00A1, 32'h3);

    seed = 32'h1ACE_B00C;
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r0, r1, r2;
      logic [5:0]  op;
      seed = seed * 32'd1664525 + 32'd1013904223; r0 = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; r1 = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; r2 = seed;
      op = (r0[3:0] == 4'hF) ? 6'h1A : 6'(r0[3:0]);
      step(r0[7:4] != 4'h0, op, r1, r2[15:0], r2 ^ r1, {r1[15:0], r2[31:16]}, r0 ^ r2);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule